// File: doc/BRIEF.md
# Sliding-Window Bipolar Autocorrelation Counter Array

This block keeps a running autocorrelation matrix for a stream of bit vectors whose bits stand for +1 and −1. It contains no multipliers. The product of two bipolar bits is their XNOR, and each stored matrix entry is a small signed counter that steps up on a +1 product and down on a −1 product. The matrix is symmetric, so only the upper triangle, diagonal included, is stored. Diagonal counters do not need an XNOR gate, because a bit times itself is always +1.

To keep the matrix over a sliding window, the caller offers the newest vector and, in the same cycle, the vector that is leaving the window. The block adds the products of the first and subtracts the products of the second. Both effects land as one net step of −2 to +2 on each counter, and the counters saturate instead of wrapping.

A parameter picks the build:
- **Parallel build:** every counter updates on the clock edge after the vectors are offered, so the block takes one vector pair per clock.
- **Sequential build:** the block latches the vectors and walks the stored entries one per cycle, holding `busy_o` high until the walk is done.

A combinational read port returns any entry by row and column. A request below the diagonal is answered from the mirrored stored entry.

Top module: `bipolar_acorr`

## Requirements
- R1: After reset every entry reads 0. A `clr_i` pulse sets every entry to 0 at the next edge, and it wins over any update offered in the same cycle.
- R2: Bit value 1 means +1 and bit value 0 means −1. When an added vector is accepted, each off-diagonal entry (i,j) steps by +1 if bits i and j are equal and by −1 if they differ.
- R3: When an added vector is accepted, each diagonal entry (i,i) steps by +1 whatever the bit values are.
- R4: When a retiring vector is accepted (`ret_valid_i`=1), each entry steps by the negation of that vector's product: −1 on the diagonal, and −1 or +1 off it.
- R5: When an add and a retire are accepted in the same cycle, each entry takes their net effect of −2, 0 or +2 as a single update.
- R6: Entries are signed 8-bit values and saturate at +127 and −128 without wrapping.
- R7: Reading row j, column i with j>i returns the stored value of entry (i,j).
- R8: In the parallel build (`PARALLEL`=1), all entries reflect an accepted vector pair at the next clock edge, and a new pair is accepted on every clock.
- R9: In the sequential build (`PARALLEL`=0), a pair is accepted only while `busy_o` is low. `busy_o` then stays high for exactly W(W+1)/2 cycles, where W=2K. Any valid input offered while `busy_o` is high is ignored. The final matrix equals what the parallel build would hold.
- R10: With both valid flags low, no entry changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of all entries |
| add_valid_i | input | 1 | Newest vector is valid |
| add_vec_i | input | 2K | Newest bipolar vector (1 = +1, 0 = −1) |
| ret_valid_i | input | 1 | Retiring vector is valid |
| ret_vec_i | input | 2K | Vector leaving the window |
| busy_o | output | 1 | Sequential walk in progress (always 0 in the parallel build) |
| rd_row_i | input | clog2(2K) | Read row index |
| rd_col_i | input | clog2(2K) | Read column index |
| rd_data_o | output | 8 | Signed entry value |

## Verification
The bench builds the design with W=4 and runs every possible add vector from a cleared matrix. For each one it reads all sixteen row and column addresses, including the mirrored ones below the diagonal. A design that swapped the XNOR polarity, left the diagonal at the wrong constant, or indexed the triangle wrongly would show a mismatch at a specific address.

A sliding window of random vectors applies adds and retires in the same cycle, which exposes a design that loses one of the two steps. Long runs of identical adds and retires drive every counter to both limits, where a wrapping counter would jump to the other sign. The sequential build is timed cycle by cycle, and the bench offers junk input while it is busy; a walk of the wrong length, or an accepted junk vector, would change `busy_o` timing or the entries.

// File: rtl/bacorr_pkg.sv
package bacorr_pkg;
  // flat index of upper-triangle entry (r,c), r<=c, row-major
  function automatic int tri_idx(int r, int c, int w);
    return (r * (2 * w - r + 1)) / 2 + (c - r);
  endfunction
endpackage

// File: rtl/bacorr_cell.sv
module bacorr_cell #(
  parameter int CW = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 en_i,
  input  logic                 add_en_i,
  input  logic                 add_prod_i,
  input  logic                 ret_en_i,
  input  logic                 ret_prod_i,
  output logic signed [CW-1:0] q_o
);
  localparam logic signed [CW+1:0] SMAX = (CW+2)'((2 ** (CW - 1)) - 1);
  localparam logic signed [CW+1:0] SMIN = -SMAX - (CW+2)'(1);

  logic signed [2:0]    d_add, d_ret, delta;
  logic signed [CW+1:0] sum;
  logic signed [CW-1:0] nxt;

  always_comb begin
    d_add = add_en_i ? (add_prod_i ? 3'sd1 : -3'sd1) : 3'sd0;
    d_ret = ret_en_i ? (ret_prod_i ? 3'sd1 : -3'sd1) : 3'sd0;
    delta = d_add - d_ret;
    sum   = (CW+2)'(q_o) + (CW+2)'(delta);
    if (sum > SMAX)      nxt = SMAX[CW-1:0];
    else if (sum < SMIN) nxt = SMIN[CW-1:0];
    else                 nxt = sum[CW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (clr_i)  q_o <= '0;
    else if (en_i)   q_o <= nxt;
  end

  p_clear_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> q_o == '0);
  p_sat_hi_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && en_i && q_o == SMAX[CW-1:0] && delta > 0) |=> q_o == SMAX[CW-1:0]);
  p_sat_lo_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && en_i && q_o == SMIN[CW-1:0] && delta < 0) |=> q_o == SMIN[CW-1:0]);
  p_net_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && en_i) |=> ((int'(q_o) - int'($past(q_o))) <= 2 &&
                          (int'(q_o) - int'($past(q_o))) >= -2));
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && (!en_i || (!add_en_i && !ret_en_i))) |=> $stable(q_o));
endmodule

// File: rtl/bacorr_seq_ctrl.sv
module bacorr_seq_ctrl #(
  parameter int W     = 64,
  parameter bit SEQ   = 1'b1,
  parameter int NENT  = W * (W + 1) / 2,
  parameter int PTRW  = $clog2(NENT + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            add_valid_i,
  input  logic [W-1:0]    add_vec_i,
  input  logic            ret_valid_i,
  input  logic [W-1:0]    ret_vec_i,
  output logic            busy_o,
  output logic [PTRW-1:0] ptr_o,
  output logic            add_en_o,
  output logic [W-1:0]    add_vec_o,
  output logic            ret_en_o,
  output logic [W-1:0]    ret_vec_o
);
  localparam logic [PTRW-1:0] LAST = PTRW'(NENT - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0; ptr_o <= '0;
      add_en_o <= 1'b0; ret_en_o <= 1'b0;
      add_vec_o <= '0; ret_vec_o <= '0;
    end else if (clr_i) begin
      busy_o <= 1'b0; ptr_o <= '0;
    end else if (busy_o) begin
      if (ptr_o == LAST) begin
        busy_o <= 1'b0; ptr_o <= '0;
      end else begin
        ptr_o <= ptr_o + 1'b1;
      end
    end else if (SEQ && (add_valid_i || ret_valid_i)) begin
      busy_o    <= 1'b1;
      ptr_o     <= '0;
      add_en_o  <= add_valid_i;
      add_vec_o <= add_vec_i;
      ret_en_o  <= ret_valid_i;
      ret_vec_o <= ret_vec_i;
    end
  end

  p_ptr_range_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> ptr_o <= LAST);
  p_ptr_walk_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !clr_i && ptr_o != LAST) |=> (busy_o && ptr_o == $past(ptr_o) + 1'b1));
  p_latch_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ($stable(add_vec_o) && $stable(ret_vec_o)));
endmodule

// File: rtl/bacorr_read.sv
module bacorr_read #(
  parameter int W    = 64,
  parameter int CW   = 8,
  parameter int NENT = W * (W + 1) / 2,
  parameter int AW   = $clog2(W)
) (
  input  logic signed [CW-1:0] ent_i [NENT],
  input  logic [AW-1:0]        row_i,
  input  logic [AW-1:0]        col_i,
  output logic signed [CW-1:0] data_o
);
  import bacorr_pkg::*;
  int lo, hi, idx;

  always_comb begin
    lo = (row_i <= col_i) ? int'(row_i) : int'(col_i);
    hi = (row_i <= col_i) ? int'(col_i) : int'(row_i);
    idx = tri_idx(lo, hi, W);
    if (hi >= W || idx >= NENT) data_o = '0;
    else                        data_o = ent_i[idx];
  end
endmodule

// File: rtl/bipolar_acorr.sv
module bipolar_acorr #(
  parameter int K        = 32,
  parameter int CW       = 8,
  parameter bit PARALLEL = 1'b1,
  parameter int W        = 2 * K,
  parameter int AW       = $clog2(W)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 add_valid_i,
  input  logic [W-1:0]         add_vec_i,
  input  logic                 ret_valid_i,
  input  logic [W-1:0]         ret_vec_i,
  output logic                 busy_o,
  input  logic [AW-1:0]        rd_row_i,
  input  logic [AW-1:0]        rd_col_i,
  output logic signed [CW-1:0] rd_data_o
);
  import bacorr_pkg::*;
  localparam int NENT = W * (W + 1) / 2;
  localparam int PTRW = $clog2(NENT + 1);

  logic [PTRW-1:0]      ptr;
  logic                 l_add_en, l_ret_en;
  logic [W-1:0]         l_add_vec, l_ret_vec;
  logic                 s_add_en, s_ret_en;
  logic [W-1:0]         s_add_vec, s_ret_vec;
  logic signed [CW-1:0] ent [NENT];

  bacorr_seq_ctrl #(.W(W), .SEQ(!PARALLEL), .NENT(NENT), .PTRW(PTRW)) u_ctrl (
    .clk_i, .rst_ni, .clr_i,
    .add_valid_i, .add_vec_i, .ret_valid_i, .ret_vec_i,
    .busy_o, .ptr_o(ptr),
    .add_en_o(l_add_en), .add_vec_o(l_add_vec),
    .ret_en_o(l_ret_en), .ret_vec_o(l_ret_vec)
  );

  // parallel build uses live inputs, sequential build the latched copy
  assign s_add_en  = PARALLEL ? add_valid_i : l_add_en;
  assign s_ret_en  = PARALLEL ? ret_valid_i : l_ret_en;
  assign s_add_vec = PARALLEL ? add_vec_i   : l_add_vec;
  assign s_ret_vec = PARALLEL ? ret_vec_i   : l_ret_vec;

  for (genvar r = 0; r < W; r++) begin : g_row
    for (genvar c = r; c < W; c++) begin : g_col
      localparam int IDX = tri_idx(r, c, W);
      logic p_add, p_ret, en;
      if (r == c) begin : g_diag
        assign p_add = 1'b1;
        assign p_ret = 1'b1;
      end else begin : g_off
        assign p_add = ~(s_add_vec[r] ^ s_add_vec[c]);
        assign p_ret = ~(s_ret_vec[r] ^ s_ret_vec[c]);
      end
      assign en = PARALLEL ? 1'b1 : (busy_o && ptr == PTRW'(IDX));
      bacorr_cell #(.CW(CW)) u_cell (
        .clk_i, .rst_ni, .clr_i, .en_i(en),
        .add_en_i(s_add_en), .add_prod_i(p_add),
        .ret_en_i(s_ret_en), .ret_prod_i(p_ret),
        .q_o(ent[IDX])
      );
    end
  end

  bacorr_read #(.W(W), .CW(CW), .NENT(NENT), .AW(AW)) u_read (
    .ent_i(ent), .row_i(rd_row_i), .col_i(rd_col_i), .data_o(rd_data_o)
  );

  p_rd_sym_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_row_i == rd_col_i) |-> rd_data_o == ent[tri_idx(int'(rd_row_i), int'(rd_row_i), W)]);
endmodule

// File: tb/sim_bipolar_acorr.sv
module sim_bipolar_acorr;
  localparam int K = 2;
  localparam int W = 2 * K;
  localparam int AW = $clog2(W);
  localparam int NENT = W * (W + 1) / 2;

  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0;
  logic av0 = 0, rv0 = 0, av1 = 0, rv1 = 0;
  logic [W-1:0] avec0 = '0, rvec0 = '0, avec1 = '0, rvec1 = '0;
  logic [AW-1:0] rd_row = '0, rd_col = '0;
  logic busy0, busy1;
  logic signed [7:0] rd0, rd1;
  int m0 [W][W];
  int m1 [W][W];
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  bipolar_acorr #(.K(K), .PARALLEL(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr),
    .add_valid_i(av0), .add_vec_i(avec0), .ret_valid_i(rv0), .ret_vec_i(rvec0),
    .busy_o(busy0), .rd_row_i(rd_row), .rd_col_i(rd_col), .rd_data_o(rd0));

  bipolar_acorr #(.K(K), .PARALLEL(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr),
    .add_valid_i(av1), .add_vec_i(avec1), .ret_valid_i(rv1), .ret_vec_i(rvec1),
    .busy_o(busy1), .rd_row_i(rd_row), .rd_col_i(rd_col), .rd_data_o(rd1));

  function automatic int sat(int v);
    return (v > 127) ? 127 : ((v < -128) ? -128 : v);
  endfunction

  function automatic void apply(int inst, logic [W-1:0] a, bit ae, logic [W-1:0] b, bit be);
    for (int r = 0; r < W; r++)
      for (int c = r; c < W; c++) begin
        int d = 0;
        if (ae) d += (a[r] == a[c]) ? 1 : -1;
        if (be) d -= (b[r] == b[c]) ? 1 : -1;
        if (inst == 0) m0[r][c] = sat(m0[r][c] + d);
        else           m1[r][c] = sat(m1[r][c] + d);
      end
  endfunction

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic check_all(int inst, string tag);
    for (int r = 0; r < W; r++)
      for (int c = 0; c < W; c++) begin
        int exp, got;
        rd_row = AW'(r); rd_col = AW'(c);
        #1;
        exp = (inst == 0) ? ((r <= c) ? m0[r][c] : m0[c][r])
                          : ((r <= c) ? m1[r][c] : m1[c][r]);
        got = (inst == 0) ? int'(rd0) : int'(rd1);
        check($sformatf("%s%s inst%0d (%0d,%0d)", tag, (r > c) ? "+R7" : "", inst, r, c), got, exp);
      end
  endtask

  task automatic clear_all(bit with_add);
    @(negedge clk);
    clr = 1'b1;
    if (with_add) begin av0 = 1'b1; avec0 = 4'b1111; end
    @(negedge clk);
    clr = 1'b0; av0 = 1'b0;
    for (int r = 0; r < W; r++)
      for (int c = 0; c < W; c++) begin m0[r][c] = 0; m1[r][c] = 0; end
  endtask

  task automatic par_step(logic [W-1:0] a, bit ae, logic [W-1:0] b, bit be);
    @(negedge clk);
    av0 = ae; avec0 = a; rv0 = be; rvec0 = b;
    @(negedge clk);
    av0 = 1'b0; rv0 = 1'b0;
    apply(0, a, ae, b, be);
  endtask

  task automatic seq_step(logic [W-1:0] a, bit ae, logic [W-1:0] b, bit be);
    int cnt = 0;
    @(negedge clk);
    av1 = ae; avec1 = a; rv1 = be; rvec1 = b;
    @(negedge clk);
    av1 = 1'b0; rv1 = 1'b0;
    while (busy1 && cnt < 1000) begin
      cnt++;
      // junk offered while busy must be ignored (R9)
      av1 = (cnt == 2); rv1 = (cnt == 2); avec1 = ~a; rvec1 = a;
      @(negedge clk);
    end
    av1 = 1'b0; rv1 = 1'b0;
    check("R9 busy length", cnt, NENT);
    apply(1, a, ae, b, be);
  endtask

  initial begin
    #(200000 * 10);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [W-1:0] hist [64];
    for (int r = 0; r < W; r++)
      for (int c = 0; c < W; c++) begin m0[r][c] = 0; m1[r][c] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all(0, "R1 reset");
    check_all(1, "R1 reset");

    // every add vector from a clear matrix: R2 off-diagonal, R3 diagonal
    for (int v = 0; v < 16; v++) begin
      clear_all(1'b0);
      par_step(4'(v), 1'b1, '0, 1'b0);
      check_all(0, "R2,R3");
    end

    // clear wins over same-cycle add
    par_step(4'b0110, 1'b1, '0, 1'b0);
    clear_all(1'b1);
    check_all(0, "R1 clear priority");

    // R10: no valid, no change
    par_step(4'b1001, 1'b1, '0, 1'b0);
    par_step(4'b0011, 1'b0, 4'b0101, 1'b0);
    check_all(0, "R10");

    // retire only: R4
    clear_all(1'b0);
    par_step('0, 1'b0, 4'b1100, 1'b1);
    check_all(0, "R4");

    // net +2/-2 in one update: R5
    clear_all(1'b0);
    par_step(4'b1111, 1'b1, 4'b0101, 1'b1);
    check_all(0, "R5");

    // back-to-back accepts every clock: R8
    clear_all(1'b0);
    @(negedge clk); av0 = 1'b1; avec0 = 4'b1010;
    @(negedge clk); avec0 = 4'b1110;
    @(negedge clk); avec0 = 4'b0001; rv0 = 1'b1; rvec0 = 4'b1010;
    @(negedge clk); av0 = 1'b0; rv0 = 1'b0;
    apply(0, 4'b1010, 1, '0, 0);
    apply(0, 4'b1110, 1, '0, 0);
    apply(0, 4'b0001, 1, 4'b1010, 1);
    check_all(0, "R8");

    // sliding window of depth 3: R4,R5
    clear_all(1'b0);
    for (int t = 0; t < 40; t++) begin
      hist[t] = 4'($urandom % 16);
      par_step(hist[t], 1'b1, (t >= 3) ? hist[t-3] : '0, t >= 3);
      check_all(0, "R4,R5 window");
    end

    // saturation: R6
    clear_all(1'b0);
    for (int i = 0; i < 135; i++) par_step(4'b1111, 1'b1, '0, 1'b0);
    check_all(0, "R6 high");
    for (int i = 0; i < 300; i++) par_step('0, 1'b0, 4'b0000, 1'b1);
    check_all(0, "R6 low");
    par_step(4'b0000, 1'b1, 4'b1111, 1'b1);
    check_all(0, "R6 low net");

    // sequential build: R9
    clear_all(1'b0);
    for (int t = 0; t < 12; t++) begin
      logic [W-1:0] a = 4'($urandom % 16);
      logic [W-1:0] b = 4'($urandom % 16);
      bit ae = (t % 3) != 2;
      bit be = (t % 2) == 1;
      if (!ae && !be) ae = 1'b1;
      seq_step(a, ae, b, be);
      check_all(1, "R9");
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule